// File: doc/BRIEF.md
# Polarity-Selectable 12-bit PWM Generator

This block produces one pulse-width-modulated waveform and drives it onto three output pins at once. Software sets a 12-bit period and a 12-bit on-time through a byte-wide register bus. Each value is split into a low byte and a high nibble. A control bit chooses whether the active level is high or low. A 12-bit counter advances once per PWM clock enable pulse. The output is active while the counter is below the on-time, and the counter wraps when it reaches the period.

The period and on-time registers are copied into shadow registers only when the counter wraps. A period that is already running therefore finishes with the values it started with. Two settings are defined outright. A zero period parks the pins at the inactive level. An on-time equal to or above a non-zero period holds the pins at the active level.

A three-state machine tracks where the waveform is:

- ST_HALT: the shadow period is zero.
- ST_ON: the active phase.
- ST_OFF: the rest of the period.

The transitions are:

- T_LOAD: on a tick that ends a period, or on any tick in ST_HALT. It copies the shadows, clears the counter and enters ST_HALT, ST_ON or ST_OFF from the new values.
- T_EXPIRE: ST_ON to ST_OFF when the incremented count reaches the on-time.
- T_HOLD: any state stays put on a cycle without a tick.

Top module: `pwm12_gen`

## Requirements
- R1: The register bus uses five addresses. Address 0 holds period bits 7:0 and address 1 holds period bits 11:8 in its bits 3:0. Address 2 holds on-time bits 7:0 and address 3 holds on-time bits 11:8 in its bits 3:0. Address 4 bit 0 is the polarity. A write takes effect at the clock edge where `bus_wr` is high. A read places the addressed value on `bus_rdata` at the edge where `bus_rd` is high, and it stays there until the next read.
- R2: After reset, every register and `bus_rdata` are 0, and all three outputs are low.
- R3: Bits 7:4 at addresses 1 and 3, and bits 7:1 at address 4, read as 0. Writes to addresses 5 to 7 change nothing, and reads from them return 0.
- R4: With polarity 0 and 0 < on-time < period, every run of period ticks holds the outputs high for exactly on-time ticks and low for the rest.
- R5: Polarity 1 inverts the waveform of R4, so the active level is low.
- R6: When the period is 0, the outputs sit at the polarity value (low for 0, high for 1) whatever the on-time.
- R7: When the period is non-zero and the on-time is greater than or equal to it, the outputs stay at the active level (high for polarity 0, low for polarity 1).
- R8: When the period is non-zero and the on-time is 0, the outputs stay at the inactive level.
- R9: The counter and the waveform advance only on cycles where `pwm_tick` is high. While `pwm_tick` stays low, the outputs do not change.
- R10: New period and on-time values take effect only at the next counter wrap. A period already under way completes with its old on-time.
- R11: `out_a`, `out_b` and `out_c` are equal on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_tick | input | 1 | PWM clock enable; one counter step per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| out_a | output | 1 | PWM output pin A |
| out_b | output | 1 | PWM output pin B |
| out_c | output | 1 | PWM output pin C |

## Verification
The bench measures active time over whole multiples of the period, so the count does not depend on the phase. A design that compares the counter with `<=` instead of `<` would report one extra active tick. A design that mishandles the zero-period or full-on-time cases would toggle where the pins should be flat, or sit at the wrong level for the selected polarity. The shadow test rewrites the on-time just after a period starts. An implementation that applies writes immediately would cut that period short. Further directed checks cover the following faults, which each break readback or hold-still behaviour:
- counting on cycles without a tick;
- exposing unimplemented high bits;
- decoding the unused addresses.

// File: rtl/pwm12_pkg.sv
package pwm12_pkg;

    // Waveform phase of the generator
    typedef enum logic [1:0] {
        ST_HALT = 2'd0,   // shadow period is zero
        ST_ON   = 2'd1,   // active phase
        ST_OFF  = 2'd2    // inactive remainder of the period
    } pwm_state_t;

    // Register offsets on the byte bus
    localparam int ADDR_PER_LO = 0;
    localparam int ADDR_PER_HI = 1;
    localparam int ADDR_DUT_LO = 2;
    localparam int ADDR_DUT_HI = 3;
    localparam int ADDR_CTRL   = 4;

endpackage

// File: rtl/pwm12_regs.sv
module pwm12_regs
    import pwm12_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  per_val,
    output logic [CNT_W-1:0]  dut_val,
    output logic              pol
);

    localparam int HI_W = CNT_W - DATA_W;

    logic [DATA_W-1:0] per_lo_q, dut_lo_q;
    logic [HI_W-1:0]   per_hi_q, dut_hi_q;
    logic              pol_q;
    logic [DATA_W-1:0] rd_mux;

    // Write decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_lo_q <= '0;
            per_hi_q <= '0;
            dut_lo_q <= '0;
            dut_hi_q <= '0;
            pol_q    <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(ADDR_PER_LO)) per_lo_q <= bus_wdata;
            if (bus_addr == ADDR_W'(ADDR_PER_HI)) per_hi_q <= bus_wdata[HI_W-1:0];
            if (bus_addr == ADDR_W'(ADDR_DUT_LO)) dut_lo_q <= bus_wdata;
            if (bus_addr == ADDR_W'(ADDR_DUT_HI)) dut_hi_q <= bus_wdata[HI_W-1:0];
            if (bus_addr == ADDR_W'(ADDR_CTRL))   pol_q    <= bus_wdata[0];
        end
    end

    // Read select, unimplemented bits padded with zero
    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(ADDR_PER_LO)) rd_mux = per_lo_q;
        if (bus_addr == ADDR_W'(ADDR_PER_HI)) rd_mux = {{(DATA_W-HI_W){1'b0}}, per_hi_q};
        if (bus_addr == ADDR_W'(ADDR_DUT_LO)) rd_mux = dut_lo_q;
        if (bus_addr == ADDR_W'(ADDR_DUT_HI)) rd_mux = {{(DATA_W-HI_W){1'b0}}, dut_hi_q};
        if (bus_addr == ADDR_W'(ADDR_CTRL))   rd_mux = {{(DATA_W-1){1'b0}}, pol_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign per_val = {per_hi_q, per_lo_q};
    assign dut_val = {dut_hi_q, dut_lo_q};
    assign pol     = pol_q;

endmodule

// File: rtl/pwm12_core.sv
module pwm12_core
    import pwm12_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] per_val,
    input  logic [CNT_W-1:0] dut_val,
    output pwm_state_t       state,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] sh_per,
    output logic [CNT_W-1:0] sh_dut
);

    pwm_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] sh_per_q, sh_per_d;
    logic [CNT_W-1:0] sh_dut_q, sh_dut_d;
    logic [CNT_W-1:0] cnt_inc;
    logic             at_wrap;
    logic             do_load;

    assign cnt_inc = cnt_q + CNT_W'(1);
    assign at_wrap = (sh_per_q == '0) || (cnt_q == sh_per_q - CNT_W'(1));
    assign do_load = tick && at_wrap;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_HALT;
            cnt_q    <= '0;
            sh_per_q <= '0;
            sh_dut_q <= '0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            sh_per_q <= sh_per_d;
            sh_dut_q <= sh_dut_d;
        end
    end

    // Next state: T_LOAD, T_EXPIRE, T_HOLD
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        sh_per_d = sh_per_q;
        sh_dut_d = sh_dut_q;
        if (do_load) begin
            cnt_d    = '0;
            sh_per_d = per_val;
            sh_dut_d = dut_val;
            if (per_val == '0)      state_d = ST_HALT;
            else if (dut_val != '0) state_d = ST_ON;
            else                    state_d = ST_OFF;
        end else if (tick) begin
            cnt_d = cnt_inc;
            unique case (state_q)
                ST_HALT: state_d = ST_HALT;
                ST_ON:   state_d = (cnt_inc < sh_dut_q) ? ST_ON : ST_OFF;
                ST_OFF:  state_d = ST_OFF;
                default: state_d = ST_HALT;
            endcase
        end
    end

    assign state  = state_q;
    assign cnt    = cnt_q;
    assign sh_per = sh_per_q;
    assign sh_dut = sh_dut_q;

endmodule

// File: rtl/pwm12_outdrv.sv
module pwm12_outdrv
    import pwm12_pkg::*;
#(
    parameter int N_OUT = 3
) (
    input  pwm_state_t       state,
    input  logic             pol,
    output logic [N_OUT-1:0] pins
);

    logic active;

    // Output process: active phase drives the level opposite to polarity
    always_comb begin
        unique case (state)
            ST_ON:   active = 1'b1;
            ST_OFF:  active = 1'b0;
            ST_HALT: active = 1'b0;
            default: active = 1'b0;
        endcase
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_pin
        assign pins[i] = active ^ pol;
    end

endmodule

// File: rtl/pwm12_gen.sv
module pwm12_gen
    import pwm12_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              out_a,
    output logic              out_b,
    output logic              out_c
);

    localparam int N_OUT = 3;

    logic [CNT_W-1:0] per_val, dut_val;
    logic             pol;
    pwm_state_t       core_state;
    logic [CNT_W-1:0] core_cnt, core_sh_per, core_sh_dut;
    logic [N_OUT-1:0] pins;

    pwm12_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .per_val   (per_val),
        .dut_val   (dut_val),
        .pol       (pol)
    );

    pwm12_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (pwm_tick),
        .per_val (per_val),
        .dut_val (dut_val),
        .state   (core_state),
        .cnt     (core_cnt),
        .sh_per  (core_sh_per),
        .sh_dut  (core_sh_dut)
    );

    pwm12_outdrv #(.N_OUT(N_OUT)) u_out (
        .state (core_state),
        .pol   (pol),
        .pins  (pins)
    );

    assign out_a = pins[0];
    assign out_b = pins[1];
    assign out_c = pins[2];

endmodule

// File: rtl/pwm12_gen_chk.sv
module pwm12_gen_chk
    import pwm12_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_tick,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              pol,
    input logic              out_a,
    input logic              out_b,
    input logic              out_c,
    input pwm_state_t        state,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  sh_per,
    input logic [CNT_W-1:0]  sh_dut
);

    localparam int HI_W = CNT_W - DATA_W;

    AST_PINS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_a == out_b) && (out_b == out_c)); // R11

    AST_HALT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_per == '0) |-> (out_a == pol)); // R6

    AST_FULL_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((sh_per != '0) && (sh_dut >= sh_per)) |-> (out_a != pol)); // R7

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        ((sh_per != '0) && (sh_dut == '0)) |-> (out_a == pol)); // R8

    AST_ON_BELOW_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON) |-> (cnt < sh_dut)); // R4

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_per != '0) |-> (cnt < sh_per)); // R4

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_tick |=> ($stable(cnt) && $stable(state))); // R9

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_tick |=> ($stable(sh_per) && $stable(sh_dut))); // R10

    AST_HI_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ((bus_addr == ADDR_W'(ADDR_PER_HI)) || (bus_addr == ADDR_W'(ADDR_DUT_HI))))
        |=> ((bus_rdata >> HI_W) == '0)); // R3

endmodule

bind pwm12_gen pwm12_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_tick  (pwm_tick),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pol       (pol),
    .out_a     (out_a),
    .out_b     (out_b),
    .out_c     (out_c),
    .state     (core_state),
    .cnt       (core_cnt),
    .sh_per    (core_sh_per),
    .sh_dut    (core_sh_dut)
);

// File: tb/sim_pwm12_gen.sv
`timescale 1ns/1ps
module sim_pwm12_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       out_a, out_b, out_c;

    int errors = 0;
    int checks = 0;
    int tick_div = 1;
    int tcnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm12_gen u0 (
        .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .out_a(out_a), .out_b(out_b), .out_c(out_c)
    );

    // Tick generator, driven away from the active edge
    always @(negedge clk) begin
        tcnt = (tick_div <= 1) ? 0 : (tcnt + 1) % tick_div;
        pwm_tick = (tick_div != 0) && (tcnt == 0);
    end

    // Vector format: {polarity, period[11:0], on-time[11:0]}
    localparam int NV = 11;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 12'd10,   12'd3},
        {1'b1, 12'd10,   12'd3},
        {1'b0, 12'd10,   12'd0},
        {1'b0, 12'd10,   12'd10},
        {1'b1, 12'd10,   12'd50},
        {1'b0, 12'd0,    12'd5},
        {1'b1, 12'd0,    12'd5},
        {1'b0, 12'd257,  12'd200},
        {1'b1, 12'd1,    12'd0},
        {1'b0, 12'd1,    12'd1},
        {1'b0, 12'd4095, 12'd1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 3'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = int'(bus_rdata);
    endtask

    task automatic cfg(input int per, input int dut, input bit p);
        wr(1, per >> 8); wr(0, per & 8'hFF);
        wr(3, dut >> 8); wr(2, dut & 8'hFF);
        wr(4, int'(p));
        repeat (4100) @(negedge clk);
    endtask

    // Count active cycles and pin mismatches over n sampled cycles
    task automatic measure(input int n, input bit p, output int act, output int mism);
        act = 0; mism = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (out_a != p) act++;
            if (!(out_a == out_b && out_b == out_c)) mism++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int d, act, mism, run, per, dut, exp_act, win;
        bit p, prev;
        string tag;

        // Reset state (R2)
        repeat (4) @(negedge clk);
        chk("R2 out during reset", int'({out_a, out_b, out_c}), 0);
        chk("R2 rdata during reset", int'(bus_rdata), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 out after reset", int'({out_a, out_b, out_c}), 0);
        for (int a = 0; a < 5; a++) begin
            rd(a, d);
            chk("R2 register reset value", d, 0);
        end

        // Register map and readback (R1, R3)
        wr(0, 8'hA5); wr(1, 8'hF3); wr(2, 8'h5A); wr(3, 8'hFE); wr(4, 8'hFF);
        rd(0, d); chk("R1 period low", d, 8'hA5);
        rd(1, d); chk("R3 period high nibble", d, 8'h03);
        rd(2, d); chk("R1 on-time low", d, 8'h5A);
        rd(3, d); chk("R3 on-time high nibble", d, 8'h0E);
        rd(4, d); chk("R3 control", d, 8'h01);
        wr(6, 8'hFF);
        rd(6, d); chk("R3 unmapped read", d, 0);
        rd(0, d); chk("R3 unmapped write ignored", d, 8'hA5);
        rd(4, d); chk("R3 control after unmapped write", d, 8'h01);

        // Vector table (R4..R8, R11)
        for (int v = 0; v < NV; v++) begin
            p   = VEC[v][24];
            per = int'(VEC[v][23:12]);
            dut = int'(VEC[v][11:0]);
            cfg(per, dut, p);
            win = (per == 0) ? 30 : 3 * per;
            exp_act = (per == 0) ? 0 : 3 * ((dut < per) ? dut : per);
            if (per == 0)        tag = "R6";
            else if (dut == 0)   tag = "R8";
            else if (dut >= per) tag = "R7";
            else if (p)          tag = "R5";
            else                 tag = "R4";
            measure(win, p, act, mism);
            chk(tag, act, exp_act);
            chk("R11 pins equal", mism, 0);
        end

        // Tick gating (R9)
        cfg(6, 3, 1'b0);
        tick_div = 0;
        repeat (3) @(negedge clk);
        prev = out_a;
        mism = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (out_a != prev) mism++;
        end
        chk("R9 no change without tick", mism, 0);
        tick_div = 3;
        repeat (40) @(negedge clk);
        measure(36, 1'b0, act, mism);
        chk("R9 tick every third cycle", act, 18);

        // Shadow update at wrap (R10)
        tick_div = 1;
        cfg(20, 10, 1'b0);
        prev = out_a;
        @(negedge clk);
        while (!(out_a && !prev)) begin
            prev = out_a;
            @(negedge clk);
        end
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 8'd2;
        run = 1;
        @(negedge clk);
        bus_wr = 1'b0;
        while (out_a) begin
            run++;
            @(negedge clk);
        end
        chk("R10 running period keeps old on-time", run, 10);
        while (!out_a) @(negedge clk);
        run = 0;
        while (out_a) begin
            run++;
            @(negedge clk);
        end
        chk("R10 next period uses new on-time", run, 2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule